// File: doc/BRIEF.md
# Compare-Match Interval Timer with DMA Request

The block is a 16-bit up-counting interval timer. A prescaler divides the peripheral clock by 4, 8, 16 or 64 and produces a one-cycle tick. On each tick the counter advances by one. When the counter equals the compare constant, that tick clears the counter instead. The same tick sets a sticky match flag and raises a one-cycle request pulse, which can serve directly as the trigger source of a DMA channel.

Software reaches four 16-bit registers through a simple write strobe and an address. The registers are start, control/status, count and constant. Read data is combinational from the address. Input capture and waveform output are not part of the block.

Top module: `cmt_dma_timer`

## Requirements
- R1: After reset the count reads 0x0000, the constant reads 0xFFFF, control/status reads 0x0000, start reads 0x0000 and `dma_req_o` is low.
- R2: Bit 0 of the start register (address 0) enables counting. While it is 0, the count holds its value and no request pulse is produced.
- R3: Control/status bits [1:0] select the divisor. Codes 0, 1, 2 and 3 give one tick every 4, 8, 16 and 64 clock cycles.
- R4: On a tick where count equals constant, the count becomes 0, the flag (control/status bit 7) becomes 1 and `dma_req_o` is high for exactly the following cycle. The match period is therefore (constant+1) times the divisor in clock cycles.
- R5: A request pulse is produced on every match, whether the flag is already set or not.
- R6: Writing control/status with bit 7 at 0 clears the flag, and writing bit 7 at 1 leaves the flag unchanged. A hardware set in the same cycle as a software clear leaves the flag at 1.
- R7: A write to the count (address 2) loads the value at the next clock edge, restarts the prescaler phase from zero and suppresses any tick in that cycle. The first tick then falls exactly one divisor period after the load.
- R8: A count above the constant keeps counting up, wraps from 0xFFFF to 0x0000, and matches only when it reaches the constant.
- R9: Read map: address 0 is start (bit 0), 1 is control/status (bit 7 flag, bits [1:0] divisor code), 2 is count and 3 is constant. All other bits read 0.
- R10: A write to the constant (address 3) stores all 16 bits and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| dma_req_o | output | 1 | One-cycle compare-match request |

## Verification
The assertions assume the smallest divisor is 4. Under that divisor a request can never occupy two consecutive cycles, and a count load can never hit the cycle in which a request is shown. The stimulus changes the write strobe, address and data only on falling edges and holds each write for a single rising edge. It drives the divisor field only with the four legal codes. Every sweep starts from a count load, so the prescaler phase is known when the pulse intervals are counted.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    ADDR_START = 2'd0,
    ADDR_CSR   = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_CONST = 2'd3
  } cmt_addr_e;

  localparam int FLAG_BIT = 7;
  localparam int CKS_W    = 2;
  localparam int NUM_DIV  = 4;

  // log2 of divisor per clock-select code: 4, 8, 16, 64
  function automatic int div_log2(input logic [CKS_W-1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 3;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CKS_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term_v [NUM_DIV];
  logic             at_term;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_term
    assign term_v[g] = PRE_W'((1 << div_log2(CKS_W'(g))) - 1);
  end

  assign at_term = (pre_q == term_v[sel_i]);
  assign tick_o  = run_i && !restart_i && at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (at_term)             pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] const_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  assign match_o = tick_i && !load_i && (cnt_q == const_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= match_o;
      if (load_i)       cnt_q <= load_val_i;
      else if (match_o) cnt_q <= '0;
      else if (tick_i)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign req_o = req_q;
endmodule

// File: rtl/cmt_dma_timer.sv
module cmt_dma_timer
  import cmt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              dma_req_o
);
  logic              start_q;
  logic [CKS_W-1:0]  cks_q;
  logic              flag_q;
  logic [DATA_W-1:0] const_q;
  logic [DATA_W-1:0] cnt_w;
  logic              tick_w, match_w;
  logic              wr_start, wr_csr, wr_cnt, wr_const;

  assign wr_start = reg_we_i && (reg_addr_i == ADDR_START);
  assign wr_csr   = reg_we_i && (reg_addr_i == ADDR_CSR);
  assign wr_cnt   = reg_we_i && (reg_addr_i == ADDR_COUNT);
  assign wr_const = reg_we_i && (reg_addr_i == ADDR_CONST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      cks_q   <= '0;
      const_q <= '1;
    end else begin
      if (wr_start) start_q <= reg_wdata_i[0];
      if (wr_csr)   cks_q   <= reg_wdata_i[CKS_W-1:0];
      if (wr_const) const_q <= reg_wdata_i;
    end
  end

  // hardware set wins over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                flag_q <= 1'b0;
    else if (match_w)                           flag_q <= 1'b1;
    else if (wr_csr && !reg_wdata_i[FLAG_BIT])  flag_q <= 1'b0;
  end

  cmt_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (start_q),
    .restart_i (wr_cnt),
    .sel_i     (cks_q),
    .tick_o    (tick_w)
  );

  cmt_counter #(.CNT_W(DATA_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .load_i     (wr_cnt),
    .load_val_i (reg_wdata_i),
    .const_i    (const_q),
    .cnt_o      (cnt_w),
    .match_o    (match_w),
    .req_o      (dma_req_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_START: reg_rdata_o[0] = start_q;
      ADDR_CSR: begin
        reg_rdata_o[FLAG_BIT]    = flag_q;
        reg_rdata_o[CKS_W-1:0]   = cks_q;
      end
      ADDR_COUNT: reg_rdata_o = cnt_w;
      default:    reg_rdata_o = const_q;
    endcase
  end
endmodule

// File: rtl/cmt_dma_timer_chk.sv
module cmt_dma_timer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              dma_req_o,
  input logic              start_q,
  input logic              flag_q,
  input logic [DATA_W-1:0] cnt_w
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> !dma_req_o); // R4
  AST_REQ_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (cnt_w == '0)); // R4
  AST_REQ_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> flag_q); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q && !(reg_we_i && reg_addr_i == 2'd2)) |=> $stable(cnt_w)); // R2
  AST_STOP_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_q |=> !dma_req_o); // R2
  AST_FLAG_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(reg_we_i && reg_addr_i == 2'd1 && !reg_wdata_i[7])); // R6
endmodule

bind cmt_dma_timer cmt_dma_timer_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .dma_req_o   (dma_req_o),
  .start_q     (start_q),
  .flag_q      (flag_q),
  .cnt_w       (cnt_w)
);

// File: tb/test_cmt_dma_timer.sv
module test_cmt_dma_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        dma_req_o;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  cmt_dma_timer i_cmt_dma_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .dma_req_o(dma_req_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!dma_req_o && n < 2000);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    int n, dv;
    int kv[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset values
    rd(2'd0, d); chk("R1 start", d, 16'h0000);
    rd(2'd1, d); chk("R1 csr", d, 16'h0000);
    rd(2'd2, d); chk("R1 count", d, 16'h0000);
    rd(2'd3, d); chk("R1 const", d, 16'hFFFF);
    chk("R1 req", dma_req_o, 0);
    // R10 / R9 constant and field readback
    wr(2'd3, 16'hA5C3); rd(2'd3, d); chk("R10 const", d, 16'hA5C3);
    wr(2'd1, 16'hFF7E); rd(2'd1, d); chk("R9 csr unused bits", d, 16'h0002);
    wr(2'd0, 16'hFFFE); rd(2'd0, d); chk("R9 start bit0", d, 16'h0000);
    // R3 R4 R5 sweep over divisor codes and constants
    for (int c = 0; c < 4; c++) begin
      dv = (c == 3) ? 64 : (4 << c);
      for (int k = 0; k < 4; k++) begin
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'(c));
        wr(2'd3, 16'(kv[k]));
        wr(2'd0, 16'h0001);
        wr(2'd2, 16'h0000);
        wait_pulse(n); chk("R3 R4 R7 first period", n, (kv[k] + 1) * dv);
        @(negedge clk_i); chk("R4 pulse width", dma_req_o, 0);
        rd(2'd1, d); chk("R4 flag set", d, 16'h0080 | c);
        wait_pulse(n); chk("R5 repeat period with flag set", n, (kv[k] + 1) * dv - 1);
      end
    end
    // R2 stopped counter holds
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0010);
    wr(2'd2, 16'h0005); rd(2'd2, d); chk("R7 count load", d, 16'h0005);
    n = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk_i); if (dma_req_o) n++; end
    rd(2'd2, d2); chk("R2 count held", d2, 16'h0005);
    chk("R2 no pulse stopped", n, 0);
    // R6 flag clearing
    wr(2'd1, 16'h0080); rd(2'd1, d); chk("R6 write one no effect", d, 16'h0000);
    // R6 set beats clear
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h0000);
    repeat (3) @(negedge clk_i);
    wr(2'd1, 16'h0000);
    rd(2'd1, d); chk("R6 set over clear", d, 16'h0080);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000); rd(2'd1, d); chk("R6 sw clear", d, 16'h0000);
    // R8 wrap above constant
    wr(2'd3, 16'h0003);
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'hFFFE);
    wait_pulse(n); chk("R8 wrap period", n, 6 * 4);
    rd(2'd2, d); chk("R8 count after match", d, 16'h0000);
    wr(2'd0, 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule